// File: doc/BRIEF.md
# Multi-Queue Almost-Full / Almost-Empty Flag Unit

This block keeps the fill level of a set of logical queues that share one storage array, and it turns those levels into two status flags. Every queue has its own occupancy counter and its own pair of threshold offsets. The counters and offsets stay live for all queues all the time. The write side and the read side each pick one active queue, and only that queue's status is driven out on the port's single flag. The write side gets an almost-full flag and the read side gets an almost-empty flag.

A port changes its active queue when its address-enable is high at a rising clock edge. A write strobe adds one entry to the write-side queue, and a read strobe removes one entry from the read-side queue. Both flags leave through a three-register pipeline, so a queue switch, a write, a read and an offset load all reach the pins with the same fixed latency. The block has no data path. Strobes are fire-and-forget, with no back-pressure: a write to a full queue or a read from an empty queue is dropped, and the caller is expected to watch the flags. Both ports share one clock.

Top module: `mq_flag_unit`

## Requirements
- R1: While `rst_n` is low, every occupancy is 0, both ports select queue 0, every offset holds its default, `af_n` is 1 and `ae_n` is 0.
- R2: With `wr_addr_en` (or `rd_addr_en`) high at a rising edge and an address below `NUM_Q`, that address becomes the port's active queue. From the third rising edge after that one, the port's flag shows the new queue's status.
- R3: A `wr_en` strobe at a rising edge adds one to the write-side queue's occupancy. If that queue already holds its depth, the strobe is dropped and the occupancy stays the same.
- R4: An `rd_en` strobe at a rising edge subtracts one from the read-side queue's occupancy. If that queue is empty, the strobe is dropped and the occupancy stays at 0.
- R5: `af_n` is active low. It reports almost-full for the write-side queue when that queue's occupancy is at least its depth D minus its almost-full offset m.
- R6: `ae_n` is active low. It reports almost-empty for the read-side queue when that queue's occupancy is at most its almost-empty offset n.
- R7: A status change caused by a write, a read or an offset load at rising edge k appears on the flags right after edge k+3.
- R8: A queue that no port is showing keeps its status current. Reads on a queue change the almost-full status the write port later shows for it, and writes change the almost-empty status the read port later shows.
- R9: With `cfg_we` high, `wr_en` and `rd_en` both low, and `cfg_qid` below `NUM_Q`, a rising edge loads `cfg_af_off` and `cfg_ae_off` into that queue. Each value is clamped to the queue's depth. A load is ignored if either strobe is high in the same cycle.
- R10: After reset every offset equals 8 when `DEF_LARGE` is 0, or 128 when it is 1, clamped to the queue's depth.
- R11: Queue q has the depth in bits [16q+15:16q] of `Q_DEPTHS`. By default even queues hold 64 entries and odd queues hold 32.
- R12: An address-enable with an address of `NUM_Q` or more leaves the port's active queue unchanged.
- R13: A write and a read on the same queue in one cycle are each judged on the occupancy before the edge. A full queue therefore drops the write and takes the read, and ends one lower.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_addr_en | input | 1 | Take `wr_addr` as the new write-side queue |
| wr_addr | input | ADDR_W | Write-side queue address |
| wr_en | input | 1 | Write strobe for the write-side queue |
| rd_addr_en | input | 1 | Take `rd_addr` as the new read-side queue |
| rd_addr | input | ADDR_W | Read-side queue address |
| rd_en | input | 1 | Read strobe for the read-side queue |
| cfg_we | input | 1 | Offset load strobe |
| cfg_qid | input | ADDR_W | Queue whose offsets are loaded |
| cfg_af_off | input | CNT_W | Almost-full offset m |
| cfg_ae_off | input | CNT_W | Almost-empty offset n |
| af_n | output | 1 | Almost-full flag of the write-side queue, active low |
| ae_n | output | 1 | Almost-empty flag of the read-side queue, active low |

## Verification
Four things are checked on every cycle. Each flag must equal the status its port computed three edges earlier. No occupancy may exceed its queue's depth. A lone write to a full queue and a lone read from an empty queue must leave the count unchanged. Queue selection must follow a valid address and must hold on an invalid one. Other behaviours only show through the bench's scenarios: the threshold arithmetic against the offsets, offset clamping and the rule that blocks a load while a strobe is high, the default offsets, paired operations on one full queue, and status carried by a queue that no port is showing until a later switch reveals it.

// File: rtl/mq_flag_pkg.sv
package mq_flag_pkg;

  localparam int MQ_MAX_Q = 32;
  localparam int MQ_DEP_W = 16;

  typedef logic [MQ_MAX_Q*MQ_DEP_W-1:0] mq_depth_vec_t;

  // Default depth layout: even queues get maxd entries, odd queues maxd/2.
  function automatic mq_depth_vec_t mq_depth_table(input int maxd);
    mq_depth_vec_t t;
    t = '0;
    for (int q = 0; q < MQ_MAX_Q; q++) begin
      t[q*MQ_DEP_W +: MQ_DEP_W] = MQ_DEP_W'((q % 2 == 0) ? maxd : maxd / 2);
    end
    return t;
  endfunction

  function automatic int mq_clamp(input int v, input int lim);
    return (v > lim) ? lim : v;
  endfunction

endpackage

// File: rtl/mq_port_sel.sv
module mq_port_sel #(
  parameter int NUM_Q  = 8,
  parameter int ADDR_W = 5,
  parameter int QW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [QW-1:0]     sel
);

  logic in_range;
  assign in_range = (addr < ADDR_W'(NUM_Q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= '0;
    end else if (addr_en && in_range) begin
      sel <= addr[QW-1:0];
    end
  end

endmodule

// File: rtl/mq_occ_bank.sv
module mq_occ_bank
  import mq_flag_pkg::*;
#(
  parameter int            NUM_Q    = 8,
  parameter int            CNT_W    = 7,
  parameter int            QW       = 3,
  parameter mq_depth_vec_t Q_DEPTHS = mq_depth_table(64)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [QW-1:0]                 wr_sel,
  input  logic                          rd_en,
  input  logic [QW-1:0]                 rd_sel,
  output logic [NUM_Q-1:0][CNT_W-1:0]   occ
);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    localparam logic [CNT_W-1:0] DEP = CNT_W'(Q_DEPTHS[q*MQ_DEP_W +: MQ_DEP_W]);
    logic [CNT_W-1:0] cnt_q;
    logic             inc, dec;

    // Both strobes are judged on the count held before the edge.
    assign inc = wr_en && (wr_sel == QW'(q)) && (cnt_q != DEP);
    assign dec = rd_en && (rd_sel == QW'(q)) && (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (inc && !dec) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (dec && !inc) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end

    assign occ[q] = cnt_q;
  end

endmodule

// File: rtl/mq_offset_regs.sv
module mq_offset_regs
  import mq_flag_pkg::*;
#(
  parameter int            NUM_Q     = 8,
  parameter int            ADDR_W    = 5,
  parameter int            CNT_W     = 7,
  parameter bit            DEF_LARGE = 1'b0,
  parameter mq_depth_vec_t Q_DEPTHS  = mq_depth_table(64)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [ADDR_W-1:0]           qid,
  input  logic [CNT_W-1:0]            af_in,
  input  logic [CNT_W-1:0]            ae_in,
  output logic [NUM_Q-1:0][CNT_W-1:0] af_off,
  output logic [NUM_Q-1:0][CNT_W-1:0] ae_off
);

  localparam int DEF_OFF = DEF_LARGE ? 128 : 8;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    localparam int               DQ  = int'(Q_DEPTHS[q*MQ_DEP_W +: MQ_DEP_W]);
    localparam logic [CNT_W-1:0] DEP = CNT_W'(DQ);
    localparam logic [CNT_W-1:0] IV  = CNT_W'(mq_clamp(DEF_OFF, DQ));
    logic [CNT_W-1:0] m_q, n_q;
    logic             hit;

    assign hit = load && (qid == ADDR_W'(q));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_q <= IV;
        n_q <= IV;
      end else if (hit) begin
        m_q <= (af_in > DEP) ? DEP : af_in;
        n_q <= (ae_in > DEP) ? DEP : ae_in;
      end
    end

    assign af_off[q] = m_q;
    assign ae_off[q] = n_q;
  end

endmodule

// File: rtl/mq_flag_pipe.sv
module mq_flag_pipe #(
  parameter int STAGES  = 3,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= {STAGES{RST_VAL}};
    end else begin
      sr <= {sr[STAGES-2:0], d};
    end
  end

  assign q = sr[STAGES-1];

endmodule

// File: rtl/mq_flag_unit.sv
module mq_flag_unit
  import mq_flag_pkg::*;
#(
  parameter int            NUM_Q      = 8,
  parameter int            ADDR_W     = 5,
  parameter int            MAX_DEPTH  = 64,
  parameter int            FLAG_STAGES = 3,
  parameter bit            DEF_LARGE  = 1'b0,
  parameter mq_depth_vec_t Q_DEPTHS   = mq_depth_table(MAX_DEPTH),
  localparam int           CNT_W      = $clog2(MAX_DEPTH + 1),
  localparam int           QW         = $clog2(NUM_Q)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_en,
  input  logic              rd_addr_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_en,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_qid,
  input  logic [CNT_W-1:0]  cfg_af_off,
  input  logic [CNT_W-1:0]  cfg_ae_off,
  output logic              af_n,
  output logic              ae_n
);

  logic [QW-1:0]                 wr_sel, rd_sel;
  logic [NUM_Q-1:0][CNT_W-1:0]   occ, af_off, ae_off, dep_arr;
  logic                          cfg_load;
  logic [CNT_W-1:0]              wr_cnt, wr_dep, wr_m, rd_cnt, rd_n;
  logic                          af_now, ae_now;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_dep
    assign dep_arr[q] = CNT_W'(Q_DEPTHS[q*MQ_DEP_W +: MQ_DEP_W]);
  end

  mq_port_sel #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W), .QW(QW)) u_wsel (
    .clk(clk), .rst_n(rst_n), .addr_en(wr_addr_en), .addr(wr_addr), .sel(wr_sel)
  );

  mq_port_sel #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W), .QW(QW)) u_rsel (
    .clk(clk), .rst_n(rst_n), .addr_en(rd_addr_en), .addr(rd_addr), .sel(rd_sel)
  );

  mq_occ_bank #(.NUM_Q(NUM_Q), .CNT_W(CNT_W), .QW(QW), .Q_DEPTHS(Q_DEPTHS)) u_occ (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel),
    .rd_en(rd_en), .rd_sel(rd_sel),
    .occ(occ)
  );

  // Offsets change only while neither strobe is active.
  assign cfg_load = cfg_we && !wr_en && !rd_en;

  mq_offset_regs #(
    .NUM_Q(NUM_Q), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .DEF_LARGE(DEF_LARGE), .Q_DEPTHS(Q_DEPTHS)
  ) u_off (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .qid(cfg_qid),
    .af_in(cfg_af_off), .ae_in(cfg_ae_off),
    .af_off(af_off), .ae_off(ae_off)
  );

  assign wr_cnt = occ[wr_sel];
  assign wr_dep = dep_arr[wr_sel];
  assign wr_m   = af_off[wr_sel];
  assign rd_cnt = occ[rd_sel];
  assign rd_n   = ae_off[rd_sel];

  // m never exceeds D, so the subtraction cannot wrap.
  assign af_now = (wr_cnt >= (wr_dep - wr_m));
  assign ae_now = (rd_cnt <= rd_n);

  mq_flag_pipe #(.STAGES(FLAG_STAGES), .RST_VAL(1'b1)) u_af_pipe (
    .clk(clk), .rst_n(rst_n), .d(~af_now), .q(af_n)
  );

  mq_flag_pipe #(.STAGES(FLAG_STAGES), .RST_VAL(1'b0)) u_ae_pipe (
    .clk(clk), .rst_n(rst_n), .d(~ae_now), .q(ae_n)
  );

endmodule

// File: rtl/mq_flag_checker.sv
module mq_flag_checker #(
  parameter int NUM_Q  = 8,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 7,
  parameter int QW     = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_addr_en,
  input logic [ADDR_W-1:0]           wr_addr,
  input logic                        wr_en,
  input logic                        rd_addr_en,
  input logic [ADDR_W-1:0]           rd_addr,
  input logic                        rd_en,
  input logic [QW-1:0]               wr_sel,
  input logic [QW-1:0]               rd_sel,
  input logic [NUM_Q-1:0][CNT_W-1:0] occ,
  input logic [NUM_Q-1:0][CNT_W-1:0] dep_arr,
  input logic                        af_now,
  input logic                        ae_now,
  input logic                        af_n,
  input logic                        ae_n
);

  logic [1:0]       cyc;
  logic [CNT_W-1:0] wcnt, rcnt, wdep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 1'b1;
  end

  assign wcnt = occ[wr_sel];
  assign rcnt = occ[rd_sel];
  assign wdep = dep_arr[wr_sel];

  assert_af_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (af_n == !$past(af_now, 3)));

  assert_ae_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (ae_n == !$past(ae_now, 3)));

  for (genvar q = 0; q < NUM_Q; q++) begin : g_ovf
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      occ[q] <= dep_arr[q]);
  end

  assert_full_write_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && !wr_addr_en && (wcnt == wdep)) |=> $stable(wcnt));

  assert_empty_read_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !rd_addr_en && (rcnt == '0)) |=> (rcnt == '0));

  assert_wsel_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr_en && (wr_addr < ADDR_W'(NUM_Q))) |=> (wr_sel == $past(wr_addr[QW-1:0])));

  assert_rsel_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_en && (rd_addr < ADDR_W'(NUM_Q))) |=> (rd_sel == $past(rd_addr[QW-1:0])));

  assert_wsel_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_addr_en || (wr_addr >= ADDR_W'(NUM_Q))) |=> $stable(wr_sel));

  assert_rsel_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_addr_en || (rd_addr >= ADDR_W'(NUM_Q))) |=> $stable(rd_sel));

endmodule

bind mq_flag_unit mq_flag_checker #(
  .NUM_Q(NUM_Q), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .QW(QW)
) u_mq_chk (
  .clk(clk), .rst_n(rst_n),
  .wr_addr_en(wr_addr_en), .wr_addr(wr_addr), .wr_en(wr_en),
  .rd_addr_en(rd_addr_en), .rd_addr(rd_addr), .rd_en(rd_en),
  .wr_sel(wr_sel), .rd_sel(rd_sel),
  .occ(occ), .dep_arr(dep_arr),
  .af_now(af_now), .ae_now(ae_now),
  .af_n(af_n), .ae_n(ae_n)
);

// File: tb/test_mq_flag_unit.sv
module test_mq_flag_unit;

  localparam int NQ = 8;
  localparam int AW = 5;
  localparam int CW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wae = 0, we = 0, rae = 0, re = 0, cwe = 0;
  logic [AW-1:0] wa = '0, ra = '0, cq = '0;
  logic [CW-1:0] caf = '0, cae = '0;
  logic af_n, ae_n;

  always #4 clk = ~clk;

  mq_flag_unit i_mq_flag_unit (
    .clk(clk), .rst_n(rst_n),
    .wr_addr_en(wae), .wr_addr(wa), .wr_en(we),
    .rd_addr_en(rae), .rd_addr(ra), .rd_en(re),
    .cfg_we(cwe), .cfg_qid(cq), .cfg_af_off(caf), .cfg_ae_off(cae),
    .af_n(af_n), .ae_n(ae_n)
  );

  int total = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R1";

  int mcnt[NQ];
  int maf[NQ];
  int mae[NQ];
  int mws = 0;
  int mrs = 0;
  bit h_af[4];
  bit h_ae[4];

  function automatic int dep(int q);
    return (q % 2 == 0) ? 64 : 32;
  endfunction

  function automatic int clampd(int v, int q);
    return (v > dep(q)) ? dep(q) : v;
  endfunction

  function automatic bit st_af();
    return mcnt[mws] >= dep(mws) - maf[mws];
  endfunction

  function automatic bit st_ae();
    return mcnt[mrs] <= mae[mrs];
  endfunction

  task automatic check(input bit act, input bit exp, input string what);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int pre[NQ];
    for (int q = 0; q < NQ; q++) pre[q] = mcnt[q];
    if (cwe && !we && !re && int'(cq) < NQ) begin
      maf[cq] = clampd(int'(caf), int'(cq));
      mae[cq] = clampd(int'(cae), int'(cq));
    end
    if (we && pre[mws] < dep(mws)) mcnt[mws]++;
    if (re && pre[mrs] > 0) mcnt[mrs]--;
    if (wae && int'(wa) < NQ) mws = int'(wa);
    if (rae && int'(ra) < NQ) mrs = int'(ra);
    for (int i = 3; i > 0; i--) begin
      h_af[i] = h_af[i-1];
      h_ae[i] = h_ae[i-1];
    end
    h_af[0] = st_af();
    h_ae[0] = st_ae();
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    model_step();
    @(negedge clk);
    check(af_n, !h_af[3], "af_n");
    check(ae_n, !h_ae[3], "ae_n");
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic sel_w(input int a);
    wae = 1; wa = AW'(a); tick(); wae = 0;
  endtask

  task automatic sel_r(input int a);
    rae = 1; ra = AW'(a); tick(); rae = 0;
  endtask

  task automatic load(input int q, input int m, input int n);
    cwe = 1; cq = AW'(q); caf = CW'(m); cae = CW'(n); tick(); cwe = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int q = 0; q < NQ; q++) begin
      mcnt[q] = 0;
      maf[q] = clampd(8, q);   // R10 default offset 8
      mae[q] = clampd(8, q);
    end
    for (int i = 0; i < 4; i++) begin
      h_af[i] = st_af();
      h_ae[i] = st_ae();
    end

    // R1: reset state on the flags
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check(af_n, 1'b1, "af_n in reset");
    check(ae_n, 1'b0, "ae_n in reset");
    rst_n = 1'b1;
    ticks(4);

    // R3 / R5 / R10: fill queue 0 (depth 64) past the default almost-full point, then overfill
    cur_req = "R10";
    we = 1; ticks(58);
    cur_req = "R3";
    ticks(12);
    we = 0; ticks(4);
    cur_req = "R5";
    check(af_n, 1'b0, "af_n with queue 0 full");

    // R4 / R6: drain queue 0 below the almost-empty point and try to underflow
    cur_req = "R6";
    re = 1; ticks(58);
    cur_req = "R4";
    ticks(10);
    re = 0; ticks(4);
    check(ae_n, 1'b0, "ae_n with queue 0 empty");

    // R9: a load during a write is ignored; an idle load takes effect; values are clamped
    cur_req = "R9";
    we = 1; ticks(10); we = 0;
    we = 1; cwe = 1; cq = 0; caf = 7'd0; cae = 7'd20; tick(); cwe = 0; we = 0;
    ticks(4);
    check(ae_n, 1'b1, "ae_n after blocked load");
    load(0, 10, 20);
    ticks(4);
    check(ae_n, 1'b0, "ae_n after idle load");
    load(1, 100, 100);
    sel_w(1);
    ticks(4);
    check(af_n, 1'b0, "af_n on queue 1 with clamped offset");
    load(9, 0, 0);
    ticks(4);

    // R2 / R8: queue 4 filled from the write port, drained from the read port out of view
    cur_req = "R2";
    load(4, 54, 8);
    sel_w(4);
    ticks(2);
    we = 1; ticks(20); we = 0;
    ticks(4);
    check(af_n, 1'b0, "af_n queue 4 at 20");
    cur_req = "R8";
    sel_w(5);
    sel_r(4);
    ticks(3);
    re = 1; ticks(15); re = 0;
    ticks(4);
    cur_req = "R2";
    sel_w(4);
    ticks(4);
    check(af_n, 1'b1, "af_n queue 4 after drain seen on reselect");

    // R12: out-of-range addresses keep the current queue
    cur_req = "R12";
    sel_w(1);
    ticks(4);
    sel_w(12);
    sel_r(20);
    ticks(4);
    check(af_n, 1'b0, "af_n still on queue 1");

    // R11 / R13: queue 1 has depth 32; paired strobes when full drop only the write
    cur_req = "R11";
    load(1, 0, 0);
    sel_r(1);
    we = 1; ticks(40); we = 0;
    ticks(4);
    check(af_n, 1'b0, "af_n queue 1 full at 32");
    cur_req = "R13";
    we = 1; re = 1; tick(); we = 0; re = 0;
    ticks(4);
    check(af_n, 1'b1, "af_n queue 1 after paired strobes");

    // R7: random traffic with queue switches, loads and both strobes
    cur_req = "R7";
    for (int i = 0; i < 4000; i++) begin
      int wb;
      wb = ((i / 400) % 2 == 1) ? 80 : 25;
      we  = (($urandom % 100) < wb);
      re  = (($urandom % 100) < (100 - wb));
      wae = (($urandom % 10) == 0);
      wa  = AW'($urandom % 12);
      rae = (($urandom % 10) == 0);
      ra  = AW'($urandom % 12);
      cwe = (($urandom % 25) == 0);
      if (cwe && (($urandom % 2) == 0)) begin
        we = 0;
        re = 0;
      end
      cq  = AW'($urandom % 10);
      caf = CW'($urandom % 80);
      cae = CW'($urandom % 80);
      tick();
    end
    we = 0; re = 0; wae = 0; rae = 0; cwe = 0;
    ticks(5);

    done = 1;
    summary();
    $finish;
  end

endmodule